// File: doc/BRIEF.md
# Multi-Channel DMA Register Front-End

This block is the register side of a sixteen-channel DMA controller. It decodes full 32-bit single-cycle accesses from a memory-mapped bus and keeps each channel's control/status word, descriptor pointer and debug word. It also holds one global enable word and one collected interrupt-status word. The descriptor fetcher and the data movers are separate blocks. The front-end gives each channel a one-cycle start pulse when software sets the channel's run bit. In the other direction it takes single-cycle completion, interrupt and idle pulses from the engines, and it shows the engines' current descriptor fields to software as read-only registers.

Two chip selects cover the address space. The low window is 4 KB. It holds channels 0 to 14, the interrupt-status word and the enable word. The high window is 256 bytes and holds only the last channel. That channel uses the same per-channel layout as the others. Reads are combinational: `rdata` is valid in the same cycle as the select. Writes take effect on the next rising clock edge.

Top module: `dma_regfront`

## Requirements
- R1: After reset, the enable word reads 0x0000FFFF, the interrupt-status word reads 0, and every channel's control/status word and descriptor pointer read 0.
- R2: A write to a control/status word (channel offset 0x00) replaces bits 0, 16–23, 28 and 29 with the written value. Bits 3, 6, 7, 9–15 and 24–27 always read 0. Bits 4 (paused), 5 (held) and 8 (error) read the engine's flag inputs `eng_flags[3c+0]`, `[3c+1]` and `[3c+2]`.
- R3: Writing 1 to bit 1 (done flag) clears it. Writing 0 leaves it unchanged.
- R4: Writing 1 to bit 2 (interrupt flag) clears it, clears the channel's bit in the interrupt-status word and drops `irq[c]`.
- R5: Bits 30 (abort) and 31 (reset) are set by writing 1. Writing 0 does not clear them. The channel's idle pulse clears them. They drive `abort_req[c]` and `reset_req[c]`.
- R6: A control/status write with bit 0 = 1 to a channel whose run bit is 0 gives `start[c]` high for that write cycle only. A write to a channel that is already running gives no pulse.
- R7: Offset 0x04 (descriptor pointer) and offset 0x20 (debug) are read/write. The pointer drives `desc_addr[32c +: 32]`.
- R8: Offsets 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C read engine field 0 to 5 (info, source, destination, length, stride, next) from `desc_fields[(6c+f)*32 +: 32]`.
- R9: In the low window, `addr[11:8]` selects channels 0–14 and `addr[7:0]` selects the register. The last channel is reached only through `sel_hi`, which ignores `addr[11:8]`.
- R10: Low-window offset 0xFE0 reads the interrupt-status word (bit c = channel c), and writes to it are ignored. Offset 0xFF0 keeps the low 16 bits written and drives `chan_en`.
- R11: An undecoded or unaligned offset reads 0, and a write to it changes no state.
- R12: `ev_done[c]` sets the done flag, `ev_irq[c]` sets the interrupt flag and raises `irq[c]`, and `ev_idle[c]` clears the run bit. A set event wins over a clearing write in the same cycle. A start write wins over a same-cycle idle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_lo | input | 1 | Select for the 4 KB window |
| sel_hi | input | 1 | Select for the 256-byte last-channel window |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte offset in the selected window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| chan_en | output | 16 | Global per-channel enable |
| start | output | 16 | Per-channel start pulse |
| abort_req | output | 16 | Per-channel abort flag |
| reset_req | output | 16 | Per-channel reset flag |
| desc_addr | output | 512 | Descriptor pointer per channel |
| irq | output | 16 | Per-channel interrupt line |
| ev_done | input | 16 | Descriptor-complete pulses |
| ev_irq | input | 16 | Interrupt-request pulses |
| ev_idle | input | 16 | Channel-idle pulses |
| eng_flags | input | 48 | Per channel {error, held, paused} |
| desc_fields | input | 3072 | Six current descriptor fields per channel |

## Verification
The hardest case to reach is an engine event and a software write that hit the same flag in the same cycle. The interrupt pulse and a write-one-to-clear of that flag have to land on one clock edge. The bench drives both from one task at the same falling edge, so they reach the flag on the same rising edge. It then checks that the flag and `irq` stay set. Start pulses are sampled while the write is still applied, because the pulse lasts only that cycle.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;
  localparam logic [31:0] CS_RW_MASK  = 32'h30FF_0001;
  localparam logic [31:0] CS_FIELD    = CS_RW_MASK & ~32'h1;
  localparam int          B_RUN       = 0;
  localparam int          B_DONE      = 1;
  localparam int          B_INTF      = 2;
  localparam int          B_ABORT     = 30;
  localparam int          B_CHRST     = 31;
  localparam logic [7:0]  OFF_CS      = 8'h00;
  localparam logic [7:0]  OFF_PTR     = 8'h04;
  localparam logic [7:0]  OFF_FLD_LO  = 8'h08;
  localparam logic [7:0]  OFF_FLD_HI  = 8'h1C;
  localparam logic [7:0]  OFF_DBG     = 8'h20;
  localparam logic [11:0] OFF_INTSTAT = 12'hFE0;
  localparam logic [11:0] OFF_GEN     = 12'hFF0;
  localparam int          NFIELD      = 6;
endpackage

// File: rtl/dma_rf_decode.sv
module dma_rf_decode
  import dma_rf_pkg::*;
#(
  parameter int NCH = 16,
  parameter int CW  = 4
) (
  input  logic          sel_lo,
  input  logic          sel_hi,
  input  logic [11:0]   addr,
  output logic          ch_hit,
  output logic [CW-1:0] ch_idx,
  output logic [7:0]    reg_off,
  output logic          fld_hit,
  output logic [2:0]    fld_idx,
  output logic          intstat_hit,
  output logic          gen_hit
);
  logic lo_chan;

  always_comb begin
    lo_chan     = sel_lo && (int'(addr[11:8]) < NCH - 1);
    ch_hit      = sel_hi || lo_chan;
    ch_idx      = sel_hi ? CW'(NCH - 1) : addr[8 +: CW];
    reg_off     = addr[7:0];
    fld_hit     = ch_hit && (reg_off[1:0] == 2'b00) &&
                  (reg_off >= OFF_FLD_LO) && (reg_off <= OFF_FLD_HI);
    fld_idx     = 3'((reg_off - OFF_FLD_LO) >> 2);
    intstat_hit = sel_lo && (addr == OFF_INTSTAT);
    gen_hit     = sel_lo && (addr == OFF_GEN);
  end
endmodule

// File: rtl/dma_rf_chan.sv
module dma_rf_chan
  import dma_rf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_cs,
  input  logic        wr_ptr,
  input  logic        wr_dbg,
  input  logic [31:0] wdata,
  input  logic        ev_done,
  input  logic        ev_irq,
  input  logic        ev_idle,
  input  logic [2:0]  flags,
  output logic [31:0] cs_o,
  output logic [31:0] ptr_o,
  output logic [31:0] dbg_o,
  output logic        start_o,
  output logic        int_o,
  output logic        abort_o,
  output logic        chrst_o
);
  logic        run_q, run_n;
  logic        done_q, done_n;
  logic        intf_q, intf_n;
  logic        abt_q, abt_n;
  logic        crs_q, crs_n;
  logic [31:0] fld_q, fld_n;
  logic        cs_en;

  always_comb begin
    run_n   = run_q;
    done_n  = done_q;
    intf_n  = intf_q;
    abt_n   = abt_q;
    crs_n   = crs_q;
    fld_n   = fld_q;
    start_o = wr_cs && wdata[B_RUN] && !run_q;
    if (wr_cs) begin
      fld_n = wdata & CS_FIELD;
      run_n = wdata[B_RUN];
      if (wdata[B_DONE])  done_n = 1'b0;
      if (wdata[B_INTF])  intf_n = 1'b0;
      if (wdata[B_ABORT]) abt_n  = 1'b1;
      if (wdata[B_CHRST]) crs_n  = 1'b1;
    end
    if (ev_done) done_n = 1'b1;
    if (ev_irq)  intf_n = 1'b1;
    if (ev_idle) begin
      abt_n = 1'b0;
      crs_n = 1'b0;
      if (!start_o) run_n = 1'b0;
    end
    cs_en = wr_cs || ev_done || ev_irq || ev_idle;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      intf_q <= 1'b0;
      abt_q  <= 1'b0;
      crs_q  <= 1'b0;
      fld_q  <= '0;
    end else if (cs_en) begin
      run_q  <= run_n;
      done_q <= done_n;
      intf_q <= intf_n;
      abt_q  <= abt_n;
      crs_q  <= crs_n;
      fld_q  <= fld_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_o <= '0;
      dbg_o <= '0;
    end else begin
      if (wr_ptr) ptr_o <= wdata;
      if (wr_dbg) dbg_o <= wdata;
    end
  end

  assign cs_o = fld_q | {crs_q, abt_q, 21'b0, flags[2], 2'b0, flags[1],
                         flags[0], 1'b0, intf_q, done_q, run_q};
  assign int_o   = intf_q;
  assign abort_o = abt_q;
  assign chrst_o = crs_q;

  AST_START_SETS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> run_q); // R6
  AST_DONE_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cs && wdata[B_DONE] && !ev_done) |=> !done_q); // R3
  AST_IRQ_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_irq |=> intf_q); // R12
  AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (abt_q && !ev_idle) |=> abt_q); // R5
  AST_FIELD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cs |=> ((cs_o & CS_FIELD) == ($past(wdata) & CS_FIELD))); // R2
endmodule

// File: rtl/dma_regfront.sv
module dma_regfront
  import dma_rf_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sel_lo,
  input  logic                     sel_hi,
  input  logic                     wr,
  input  logic [11:0]              addr,
  input  logic [31:0]              wdata,
  output logic [31:0]              rdata,
  output logic [NCH-1:0]           chan_en,
  output logic [NCH-1:0]           start,
  output logic [NCH-1:0]           abort_req,
  output logic [NCH-1:0]           reset_req,
  output logic [NCH*32-1:0]        desc_addr,
  output logic [NCH-1:0]           irq,
  input  logic [NCH-1:0]           ev_done,
  input  logic [NCH-1:0]           ev_irq,
  input  logic [NCH-1:0]           ev_idle,
  input  logic [NCH*3-1:0]         eng_flags,
  input  logic [NCH*NFIELD*32-1:0] desc_fields
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

  logic          ch_hit, fld_hit, intstat_hit, gen_hit, wr_go;
  logic [CW-1:0] ch_idx;
  logic [7:0]    reg_off;
  logic [2:0]    fld_idx;
  logic [31:0]   cs_arr  [NCH];
  logic [31:0]   ptr_arr [NCH];
  logic [31:0]   dbg_arr [NCH];
  logic [NCH-1:0] gen_q, int_vec;

  assign wr_go = (sel_lo || sel_hi) && wr;

  dma_rf_decode #(.NCH(NCH), .CW(CW)) u_dec (
    .sel_lo(sel_lo), .sel_hi(sel_hi), .addr(addr),
    .ch_hit(ch_hit), .ch_idx(ch_idx), .reg_off(reg_off),
    .fld_hit(fld_hit), .fld_idx(fld_idx),
    .intstat_hit(intstat_hit), .gen_hit(gen_hit)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic this_ch;
    assign this_ch = wr_go && ch_hit && (ch_idx == CW'(c));
    dma_rf_chan u_ch (
      .clk(clk), .rst_n(rst_n),
      .wr_cs (this_ch && (reg_off == OFF_CS)),
      .wr_ptr(this_ch && (reg_off == OFF_PTR)),
      .wr_dbg(this_ch && (reg_off == OFF_DBG)),
      .wdata(wdata),
      .ev_done(ev_done[c]), .ev_irq(ev_irq[c]), .ev_idle(ev_idle[c]),
      .flags(eng_flags[c*3 +: 3]),
      .cs_o(cs_arr[c]), .ptr_o(ptr_arr[c]), .dbg_o(dbg_arr[c]),
      .start_o(start[c]), .int_o(int_vec[c]),
      .abort_o(abort_req[c]), .chrst_o(reset_req[c])
    );
    assign desc_addr[c*32 +: 32] = ptr_arr[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gen_q <= '1;
    else if (wr_go && gen_hit) gen_q <= wdata[NCH-1:0];
  end

  assign chan_en = gen_q;
  assign irq     = int_vec;

  always_comb begin
    rdata = '0;
    if (ch_hit) begin
      if (fld_hit)                rdata = desc_fields[(int'(ch_idx)*NFIELD + int'(fld_idx))*32 +: 32];
      else if (reg_off == OFF_CS)  rdata = cs_arr[ch_idx];
      else if (reg_off == OFF_PTR) rdata = ptr_arr[ch_idx];
      else if (reg_off == OFF_DBG) rdata = dbg_arr[ch_idx];
    end else if (intstat_hit) begin
      rdata = 32'(int_vec);
    end else if (gen_hit) begin
      rdata = 32'(gen_q);
    end
  end

  AST_ONE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_lo && sel_hi)); // R9
  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_lo || sel_hi) |-> (rdata == 32'h0)); // R11
  AST_GEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_go && gen_hit) |=> (chan_en == $past(chan_en))); // R10
endmodule

// File: tb/dma_regfront_test.sv
`timescale 1ns/1ps
module dma_regfront_test;
  localparam int NCH = 16;
  localparam int NV  = 23;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              sel_lo, sel_hi, wr;
  logic [11:0]       addr;
  logic [31:0]       wdata, rdata;
  logic [NCH-1:0]    chan_en, start, abort_req, reset_req, irq;
  logic [NCH*32-1:0] desc_addr;
  logic [NCH-1:0]    ev_done, ev_irq, ev_idle;
  logic [NCH*3-1:0]  eng_flags;
  logic [NCH*6*32-1:0] desc_fields;

  int n_tests = 0;
  int n_fail  = 0;
  logic [NCH-1:0] seen_start;

  always #2 clk = ~clk;

  dma_regfront #(.NCH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .sel_lo(sel_lo), .sel_hi(sel_hi), .wr(wr),
    .addr(addr), .wdata(wdata), .rdata(rdata), .chan_en(chan_en),
    .start(start), .abort_req(abort_req), .reset_req(reset_req),
    .desc_addr(desc_addr), .irq(irq), .ev_done(ev_done), .ev_irq(ev_irq),
    .ev_idle(ev_idle), .eng_flags(eng_flags), .desc_fields(desc_fields)
  );

  // {tag(4), hi window(1), write(1), addr(12), wdata(32), expected(32)}
  typedef logic [81:0] vec_t;
  localparam vec_t VEC [NV] = '{
    {4'd1,  1'b0, 1'b0, 12'hFF0, 32'h0,         32'h0000_FFFF}, // R1
    {4'd1,  1'b0, 1'b0, 12'hFE0, 32'h0,         32'h0},         // R1
    {4'd1,  1'b0, 1'b0, 12'h300, 32'h0,         32'h0},         // R1
    {4'd1,  1'b0, 1'b0, 12'h304, 32'h0,         32'h0},         // R1
    {4'd7,  1'b0, 1'b1, 12'h204, 32'h1234_5670, 32'h0},         // R7
    {4'd7,  1'b0, 1'b0, 12'h204, 32'h0,         32'h1234_5670}, // R7
    {4'd7,  1'b0, 1'b1, 12'h220, 32'hCAFE_0001, 32'h0},         // R7
    {4'd7,  1'b0, 1'b0, 12'h220, 32'h0,         32'hCAFE_0001}, // R7
    {4'd8,  1'b0, 1'b0, 12'h50C, 32'h0,         32'hD000_0501}, // R8
    {4'd8,  1'b0, 1'b0, 12'h71C, 32'h0,         32'hD000_0705}, // R8
    {4'd8,  1'b0, 1'b0, 12'hE08, 32'h0,         32'hD000_0E00}, // R8
    {4'd9,  1'b1, 1'b0, 12'h010, 32'h0,         32'hD000_0F02}, // R9
    {4'd10, 1'b0, 1'b1, 12'hFF0, 32'hABCD_1234, 32'h0},         // R10
    {4'd10, 1'b0, 1'b0, 12'hFF0, 32'h0,         32'h0000_1234}, // R10
    {4'd10, 1'b0, 1'b1, 12'hFE0, 32'hFFFF_FFFF, 32'h0},         // R10
    {4'd10, 1'b0, 1'b0, 12'hFE0, 32'h0,         32'h0},         // R10
    {4'd11, 1'b0, 1'b0, 12'h024, 32'h0,         32'h0},         // R11
    {4'd11, 1'b0, 1'b1, 12'h224, 32'hFFFF_FFFF, 32'h0},         // R11
    {4'd11, 1'b0, 1'b0, 12'h204, 32'h0,         32'h1234_5670}, // R11
    {4'd9,  1'b1, 1'b1, 12'h104, 32'hF00D_0000, 32'h0},         // R9
    {4'd9,  1'b1, 1'b0, 12'h004, 32'h0,         32'hF00D_0000}, // R9
    {4'd9,  1'b0, 1'b0, 12'hF04, 32'h0,         32'h0},         // R9
    {4'd11, 1'b0, 1'b0, 12'h206, 32'h0,         32'h0}          // R11
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic hi, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    sel_lo = !hi; sel_hi = hi; wr = 1'b1; addr = a; wdata = d;
    #1 seen_start = start;
    @(negedge clk);
    sel_lo = 1'b0; sel_hi = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_wr_ev(input logic [11:0] a, input logic [31:0] d,
                           input logic [NCH-1:0] dn, input logic [NCH-1:0] iq,
                           input logic [NCH-1:0] il);
    @(negedge clk);
    sel_lo = 1'b1; wr = 1'b1; addr = a; wdata = d;
    ev_done = dn; ev_irq = iq; ev_idle = il;
    #1 seen_start = start;
    @(negedge clk);
    sel_lo = 1'b0; wr = 1'b0; ev_done = '0; ev_irq = '0; ev_idle = '0;
  endtask

  task automatic bus_rd(input logic hi, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    sel_lo = !hi; sel_hi = hi; wr = 1'b0; addr = a;
    #1 d = rdata;
    sel_lo = 1'b0; sel_hi = 1'b0;
  endtask

  task automatic pulse_ev(input logic [NCH-1:0] dn, input logic [NCH-1:0] iq,
                          input logic [NCH-1:0] il);
    @(negedge clk);
    ev_done = dn; ev_irq = iq; ev_idle = il;
    @(negedge clk);
    ev_done = '0; ev_irq = '0; ev_idle = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; sel_lo = 1'b0; sel_hi = 1'b0; wr = 1'b0;
    addr = '0; wdata = '0; ev_done = '0; ev_irq = '0; ev_idle = '0;
    eng_flags = '0; seen_start = '0;
    for (int c = 0; c < NCH; c++)
      for (int f = 0; f < 6; f++)
        desc_fields[(c*6+f)*32 +: 32] = 32'hD000_0000 | (c << 8) | f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    chk("R1 start idle", 32'(start), 32'h0);
    chk("R1 irq idle", 32'(irq), 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][76]) bus_wr(VEC[i][77], VEC[i][75:64], VEC[i][63:32]);
      else begin
        bus_rd(VEC[i][77], VEC[i][75:64], r);
        chk($sformatf("R%0d vec%0d", VEC[i][81:78], i), r, VEC[i][31:0]);
      end
    end
    chk("R7 ptr port", desc_addr[2*32 +: 32], 32'h1234_5670);
    chk("R10 enable port", 32'(chan_en), 32'h1234);

    // R2 field mask and engine flags
    bus_wr(1'b0, 12'h100, 32'h3FFF_FFF0);
    chk("R6 no start on run=0", 32'(seen_start), 32'h0);
    bus_rd(1'b0, 12'h100, r); chk("R2 masked field", r, 32'h30FF_0000);
    eng_flags[1*3 +: 3] = 3'b111;
    bus_rd(1'b0, 12'h100, r); chk("R2 engine flags", r, 32'h30FF_0130);
    eng_flags = '0;
    // R5 abort/reset sticky, cleared by idle
    bus_wr(1'b0, 12'h100, 32'hC000_0000);
    bus_rd(1'b0, 12'h100, r); chk("R5 set", r, 32'hC000_0000);
    chk("R5 outputs", {30'b0, reset_req[1], abort_req[1]}, 32'h3);
    bus_wr(1'b0, 12'h100, 32'h0);
    bus_rd(1'b0, 12'h100, r); chk("R5 sticky", r, 32'hC000_0000);
    pulse_ev('0, '0, 16'h0002);
    bus_rd(1'b0, 12'h100, r); chk("R5 idle clears", r, 32'h0);
    // R6 start pulse
    bus_wr(1'b0, 12'h100, 32'h1);
    chk("R6 start pulse", 32'(seen_start), 32'h0000_0002);
    chk("R6 pulse one cycle", 32'(start), 32'h0);
    bus_rd(1'b0, 12'h100, r); chk("R6 running", r, 32'h1);
    bus_wr(1'b0, 12'h100, 32'h1);
    chk("R6 no restart", 32'(seen_start), 32'h0);
    pulse_ev('0, '0, 16'h0002);
    bus_rd(1'b0, 12'h100, r); chk("R12 idle clears run", r, 32'h0);
    bus_wr(1'b1, 12'h000, 32'h1);
    chk("R9 last channel start", 32'(seen_start), 32'h0000_8000);
    // R12 events, R3 / R4 write-one-to-clear
    pulse_ev(16'h0002, 16'h0002, '0);
    bus_rd(1'b0, 12'h100, r); chk("R12 done+int set", r, 32'h6);
    chk("R12 irq line", 32'(irq), 32'h0000_0002);
    bus_rd(1'b0, 12'hFE0, r); chk("R12 int status", r, 32'h2);
    bus_wr(1'b0, 12'h100, 32'h2);
    bus_rd(1'b0, 12'h100, r); chk("R3 done cleared", r, 32'h4);
    bus_wr_ev(12'h100, 32'h4, '0, 16'h0002, '0);
    bus_rd(1'b0, 12'h100, r); chk("R12 event beats clear", r, 32'h4);
    chk("R12 irq kept", 32'(irq), 32'h0000_0002);
    bus_wr(1'b0, 12'h100, 32'h4);
    bus_rd(1'b0, 12'h100, r); chk("R4 int cleared", r, 32'h0);
    chk("R4 irq dropped", 32'(irq), 32'h0);
    bus_rd(1'b0, 12'hFE0, r); chk("R4 status cleared", r, 32'h0);
    // R12 start beats same-cycle idle
    bus_wr_ev(12'h300, 32'h1, '0, '0, 16'h0008);
    bus_rd(1'b0, 12'h300, r); chk("R12 start beats idle", r, 32'h1);

    // R1 reset again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    bus_rd(1'b0, 12'h300, r); chk("R1 cs after reset", r, 32'h0);
    bus_rd(1'b0, 12'h204, r); chk("R1 ptr after reset", r, 32'h0);
    bus_rd(1'b0, 12'hFF0, r); chk("R1 enable after reset", r, 32'h0000_FFFF);
    bus_rd(1'b1, 12'h004, r); chk("R1 last ptr after reset", r, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule